// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block takes a stream of 32-bit configuration words, one per accepted cycle over a valid/ready handshake. It ignores everything until it sees a fixed synchronization word. After that it reads each following word as a packet header and sends the payload on as register writes or read requests. The packet header comes in two forms. The short-count form carries a register address and an 11-bit word count. The long-count form carries only a 27-bit word count and reuses the address of the most recent short-count header.

Each payload word of a write packet appears on a one-cycle write strobe with its address and data. Writes to the command register also pulse a separate command strobe that carries the value. For a read packet the block raises a read request once per counted word. It holds the input stalled until each request is acknowledged. A 9-bit status word reports alignment, a sticky active-low error flag, read activity and completion. Writing the desynchronize code to the command register drops the decoder back into sync search.

Top module: `cfg_stream_decoder`

## Requirements
- R1: After reset, `status` is 9'h13F, `in_ready` is 1, and `wr_en`, `cmd_wr` and `rd_req` are 0.
- R2: Before the word 32'hAA995566 is accepted, no word causes any strobe and `status[7]` stays 0. Accepting that word sets `status[7]` to 1. When the decoder is already aligned, that word is ignored.
- R3: The word 32'hFFFFFFFF is ignored in every state. It causes no strobe, and it is not counted as a payload word.
- R4: A header with bits [31:29]=1 and [28:27]=2 is a short write. Its address is bits [16:13] and its count is bits [10:0]. Each of the next count non-pad words appears one cycle after acceptance on `wr_en`, `wr_addr` and `wr_data`. The word after the last one is a header.
- R5: A header with type 1 and opcode 0, or any header whose count is 0, is a no-operation. It consumes no payload, whatever its count field holds.
- R6: A header with bits [31:29]=2 takes its count from bits [26:0] and its address from the latest type-1 header. Opcode 2 means write and opcode 1 means read.
- R7: For a read packet (opcode 1), `rd_req` is 1 with `rd_addr` equal to the packet address. `in_ready` is 0 and `status[6]` is 1 until `rd_ack` has been seen once per counted word. After that, `in_ready` returns to 1.
- R8: A payload write to address 4 also pulses `cmd_wr`, with `cmd_data` equal to the written word, in the same cycle as `wr_en`.
- R9: Writing 13 to address 4 clears `status[7]` in the cycle of its strobe. It drops the rest of that packet and returns the decoder to sync search.
- R10: A header whose type is neither 1 nor 2, or whose opcode is 3, is dropped and clears `status[8]`. So is a type-2 header that has no type-1 header before it since the last sync. `status[8]` stays 0 until reset.
- R11: `status[5:1]` always reads 5'b11111. `status[0]` is 1 exactly when no packet payload or read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Configuration word |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 4 | Register write address |
| wr_data | output | 32 | Register write data |
| cmd_wr | output | 1 | Command register write strobe |
| cmd_data | output | 32 | Command value |
| rd_req | output | 1 | Register read request |
| rd_addr | output | 4 | Register read address |
| rd_ack | input | 1 | Read result accepted |
| status | output | 9 | Status flags |

## Verification
The case that is hardest to reach from the ports is a long-count packet whose count is wider than the 11-bit short field. It only decodes correctly if bits above bit 10 are honoured. The address it writes to is never stated in its own header. The stimulus first sends a short header to set the address, then a long header with count 2049, and streams every payload word. It checks that word 2049 still writes and that the following word is taken as a header. Random short write packets with pad words mixed in cover ordinary traffic. Directed sequences cover desynchronization partway through a packet, a long header with no short header before it, and a read stalled across cycles that have no acknowledge.

// File: rtl/cfgdec_pkg.sv
// Package: shared types and fixed header field layout for the decoder.
// Assumes 32-bit words; field positions are fixed by the stream format.
package cfgdec_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 27;
    localparam int SCNT_W  = 11;
    localparam int STAT_W  = 9;
    localparam int TYPE_LO = 29;
    localparam int OP_LO   = 27;
    localparam int ADDR_LO = 13;

    localparam logic [WORD_W-1:0] PAD_WORD = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_SEARCH,
        ST_HEADER,
        ST_WRITE,
        ST_READ
    } dec_state_t;

    typedef enum logic [1:0] {
        HK_NOOP,
        HK_WRITE,
        HK_READ,
        HK_BAD
    } hdr_kind_t;

    typedef struct packed {
        hdr_kind_t         kind;
        logic              is_short;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } hdr_info_t;
endpackage

// File: rtl/cfgdec_hdr.sv
// Module: combinational header decoder.
// Splits a header word into kind, address and count. Long headers borrow
// the address of the latest short header; they are bad if none exists.
module cfgdec_hdr
    import cfgdec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              have_short,
    input  logic [ADDR_W-1:0] last_addr,
    output hdr_info_t         info
);
    logic [2:0] htype;
    logic [1:0] hop;

    assign htype = word[TYPE_LO +: 3];
    assign hop   = word[OP_LO +: 2];

    // Classify the header and extract its fields.
    always_comb begin
        info          = '0;
        info.kind     = HK_BAD;
        info.is_short = 1'b0;
        info.addr     = last_addr;
        info.cnt      = '0;
        if (htype == 3'd1) begin
            info.is_short = 1'b1;
            info.addr     = word[ADDR_LO +: ADDR_W];
            info.cnt      = {{(CNT_W-SCNT_W){1'b0}}, word[SCNT_W-1:0]};
        end else if (htype == 3'd2 && have_short) begin
            info.cnt = word[CNT_W-1:0];
        end
        if (htype == 3'd1 || (htype == 3'd2 && have_short)) begin
            unique case (hop)
                2'd0:    info.kind = HK_NOOP;
                2'd1:    info.kind = (info.cnt == '0) ? HK_NOOP : HK_READ;
                2'd2:    info.kind = (info.cnt == '0) ? HK_NOOP : HK_WRITE;
                default: info.kind = HK_BAD;
            endcase
        end
    end
endmodule

// File: rtl/cfgdec_fsm.sv
// Module: stream sequencer.
// Tracks sync search, header and payload phases, counts payload words,
// issues write and read strobes, and reports sync/desync/bad events.
// Assumes pad words are never payload and never counted.
module cfgdec_fsm
    import cfgdec_pkg::*;
#(
    parameter logic [WORD_W-1:0] SYNC_WORD   = 32'hAA99_5566,
    parameter logic [ADDR_W-1:0] CMD_ADDR    = 4'd4,
    parameter logic [WORD_W-1:0] DESYNC_CODE = 32'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              cmd_wr,
    output logic [WORD_W-1:0] cmd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    output logic              ev_sync,
    output logic              ev_desync,
    output logic              ev_bad,
    output logic              busy_rd,
    output logic              idle
);
    dec_state_t        state;
    logic [CNT_W-1:0]  remain;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] last_addr;
    logic              have_short;
    logic              take;
    logic              is_sync;
    logic              is_desync;
    hdr_info_t         hinfo;

    cfgdec_hdr u_hdr (
        .word       (in_data),
        .have_short (have_short),
        .last_addr  (last_addr),
        .info       (hinfo)
    );

    // Handshake and word classification.
    always_comb begin
        in_ready  = (state != ST_READ);
        take      = in_valid && in_ready && (in_data != PAD_WORD);
        is_sync   = (in_data == SYNC_WORD);
        is_desync = (cur_addr == CMD_ADDR) && (in_data == DESYNC_CODE);
        ev_sync   = (state == ST_SEARCH) && take && is_sync;
        ev_desync = (state == ST_WRITE) && take && is_desync;
        ev_bad    = (state == ST_HEADER) && take && !is_sync && (hinfo.kind == HK_BAD);
        rd_req    = (state == ST_READ);
        rd_addr   = cur_addr;
        busy_rd   = (state == ST_READ);
        idle      = (state == ST_SEARCH) || (state == ST_HEADER);
    end

    // Phase sequencing, payload counting and registered write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_SEARCH;
            remain     <= '0;
            cur_addr   <= '0;
            last_addr  <= '0;
            have_short <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            cmd_wr     <= 1'b0;
            cmd_data   <= '0;
        end else begin
            wr_en  <= 1'b0;
            cmd_wr <= 1'b0;
            unique case (state)
                ST_SEARCH: begin
                    if (take && is_sync) state <= ST_HEADER;
                end
                ST_HEADER: begin
                    if (take && !is_sync) begin
                        if (hinfo.is_short) begin
                            last_addr  <= hinfo.addr;
                            have_short <= 1'b1;
                        end
                        if (hinfo.kind == HK_WRITE || hinfo.kind == HK_READ) begin
                            cur_addr <= hinfo.addr;
                            remain   <= hinfo.cnt;
                            state    <= (hinfo.kind == HK_WRITE) ? ST_WRITE : ST_READ;
                        end
                    end
                end
                ST_WRITE: begin
                    if (take) begin
                        wr_en   <= 1'b1;
                        wr_addr <= cur_addr;
                        wr_data <= in_data;
                        if (cur_addr == CMD_ADDR) begin
                            cmd_wr   <= 1'b1;
                            cmd_data <= in_data;
                        end
                        if (is_desync) begin
                            state      <= ST_SEARCH;
                            have_short <= 1'b0;
                        end else if (remain == CNT_W'(1)) begin
                            state <= ST_HEADER;
                        end else begin
                            remain <= remain - 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_ack) begin
                        if (remain == CNT_W'(1)) state <= ST_HEADER;
                        else remain <= remain - 1'b1;
                    end
                end
                default: state <= ST_SEARCH;
            endcase
        end
    end
endmodule

// File: rtl/cfgdec_status.sv
// Module: status flag register.
// Holds the alignment flag and the sticky active-low error flag, and
// assembles the status word from them and the sequencer's phase.
module cfgdec_status
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_sync,
    input  logic              ev_desync,
    input  logic              ev_bad,
    input  logic              busy_rd,
    input  logic              idle,
    output logic [STAT_W-1:0] status
);
    logic aligned;
    logic err_n;

    // Alignment follows sync/desync events; error is sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned <= 1'b0;
            err_n   <= 1'b1;
        end else begin
            if (ev_sync)   aligned <= 1'b1;
            if (ev_desync) aligned <= 1'b0;
            if (ev_bad)    err_n   <= 1'b0;
        end
    end

    // Status word layout.
    always_comb begin
        status      = '0;
        status[8]   = err_n;
        status[7]   = aligned;
        status[6]   = busy_rd;
        status[5:1] = 5'b11111;
        status[0]   = idle;
    end
endmodule

// File: rtl/cfg_stream_decoder.sv
// Module: top of the configuration packet stream decoder.
// Wires the sequencer and the status register together.
// Assumes rd_ack is only meaningful while rd_req is high.
module cfg_stream_decoder
    import cfgdec_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD   = 32'hAA99_5566,
    parameter logic [3:0]  CMD_ADDR    = 4'd4,
    parameter logic [31:0] DESYNC_CODE = 32'd13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        wr_en,
    output logic [3:0]  wr_addr,
    output logic [31:0] wr_data,
    output logic        cmd_wr,
    output logic [31:0] cmd_data,
    output logic        rd_req,
    output logic [3:0]  rd_addr,
    input  logic        rd_ack,
    output logic [8:0]  status
);
    logic ev_sync;
    logic ev_desync;
    logic ev_bad;
    logic busy_rd;
    logic idle;

    cfgdec_fsm #(
        .SYNC_WORD   (SYNC_WORD),
        .CMD_ADDR    (CMD_ADDR),
        .DESYNC_CODE (DESYNC_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmd_wr    (cmd_wr),
        .cmd_data  (cmd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_ack    (rd_ack),
        .ev_sync   (ev_sync),
        .ev_desync (ev_desync),
        .ev_bad    (ev_bad),
        .busy_rd   (busy_rd),
        .idle      (idle)
    );

    cfgdec_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_sync   (ev_sync),
        .ev_desync (ev_desync),
        .ev_bad    (ev_bad),
        .busy_rd   (busy_rd),
        .idle      (idle),
        .status    (status)
    );
endmodule

// File: rtl/cfg_stream_decoder_chk.sv
// Module: assertion checker bound to the decoder top.
module cfg_stream_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        in_ready,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        cmd_wr,
    input logic [31:0] cmd_data,
    input logic        rd_req,
    input logic [3:0]  rd_addr,
    input logic        rd_ack,
    input logic [8:0]  status
);
    a_r2_align_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> $past(in_valid && in_ready && in_data == 32'hAA99_5566));

    a_r2_write_only_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(status[7]));

    a_r3_pad_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_data == 32'hFFFF_FFFF) |-> !wr_en);

    a_r7_stall_while_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (!in_ready && status[6] && !status[0]));

    a_r8_cmd_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> (wr_en && wr_addr == 4'd4 && cmd_data == wr_data));

    a_r9_desync_drops_align: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data == 32'd13) |-> !status[7]);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !status[8] |=> !status[8]);

    a_r11_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:1] == 5'b11111);
endmodule

bind cfg_stream_decoder cfg_stream_decoder_chk u_chk (.*);

// File: tb/test_cfg_stream_decoder.sv
module test_cfg_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic        cmd_wr;
    logic [31:0] cmd_data;
    logic        rd_req;
    logic [3:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [8:0]  status;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    localparam logic [31:0] SYNC = 32'hAA99_5566;
    localparam logic [31:0] PAD  = 32'hFFFF_FFFF;

    always #10 clk = ~clk;

    cfg_stream_decoder i_cfg_stream_decoder (.*);

    function automatic logic [31:0] hdr_short(input logic [1:0] op, input logic [3:0] a,
                                              input logic [10:0] n);
        return {3'd1, op, 10'd0, a, 2'd0, n};
    endfunction

    function automatic logic [31:0] hdr_long(input logic [1:0] op, input logic [26:0] n);
        return {3'd2, op, n};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        rd_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one word for one edge; outputs are read just after that edge.
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic expect_wr(input string req, input logic [3:0] a, input logic [31:0] d);
        chk(req, {31'd0, wr_en}, 32'd1);
        chk(req, {28'd0, wr_addr}, {28'd0, a});
        chk(req, wr_data, d);
    endtask

    task automatic expect_none(input string req);
        chk(req, {31'd0, wr_en}, 32'd0);
        chk(req, {31'd0, cmd_wr}, 32'd0);
    endtask

    task automatic ack_read();
        @(negedge clk);
        rd_ack = 1'b1;
        @(posedge clk);
        #1;
        rd_ack = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd4711));
        do_reset();
        #1;
        // R1 and R11: reset state
        chk("R1 status", {23'd0, status}, 32'h13F);
        chk("R1 ready", {31'd0, in_ready}, 32'd1);
        chk("R1 strobes", {29'd0, wr_en, cmd_wr, rd_req}, 32'd0);

        // R2: words before sync are dropped
        send(hdr_short(2'd2, 4'd3, 11'd1));
        send(32'h1234_5678);
        expect_none("R2 pre-sync");
        chk("R2 unaligned", {31'd0, status[7]}, 32'd0);
        send(PAD);
        send(SYNC);
        chk("R2 aligned", {31'd0, status[7]}, 32'd1);
        send(SYNC);
        chk("R2 resync ignored", {31'd0, status[0]}, 32'd1);

        // R4, R3, R11: short write with a pad in the middle
        send(hdr_short(2'd2, 4'd3, 11'd2));
        chk("R11 pending", {31'd0, status[0]}, 32'd0);
        send(32'hA000_0001);
        expect_wr("R4 word1", 4'd3, 32'hA000_0001);
        send(PAD);
        expect_none("R3 pad mid-packet");
        send(32'hA000_0002);
        expect_wr("R4 word2", 4'd3, 32'hA000_0002);
        chk("R11 done", {31'd0, status[0]}, 32'd1);

        // R5: no-operation with a nonzero count field
        send(hdr_short(2'd0, 4'd9, 11'd5));
        send(hdr_short(2'd2, 4'd7, 11'd1));
        expect_none("R5 noop");
        send(32'hB000_0007);
        expect_wr("R5 after noop", 4'd7, 32'hB000_0007);

        // R6: long packet, count above 11 bits, address from type-1 header
        send(hdr_long(2'd2, 27'd2049));
        for (int i = 0; i < 2049; i++) begin
            send(32'h0C00_0000 + 32'(i));
            if (i == 0 || i == 2048) expect_wr("R6 long word", 4'd7, 32'h0C00_0000 + 32'(i));
            if (i == 2047) chk("R6 still pending", {31'd0, status[0]}, 32'd0);
        end
        chk("R6 long ended", {31'd0, status[0]}, 32'd1);

        // R7: read packet stalls input until each ack
        send(hdr_short(2'd1, 4'd9, 11'd2));
        chk("R7 req", {31'd0, rd_req}, 32'd1);
        chk("R7 addr", {28'd0, rd_addr}, 32'd9);
        chk("R7 stall", {31'd0, in_ready}, 32'd0);
        chk("R7 rip", {31'd0, status[6]}, 32'd1);
        repeat (3) @(posedge clk);
        #1;
        chk("R7 held without ack", {30'd0, rd_req, in_ready}, 32'd2);
        ack_read();
        chk("R7 second word", {30'd0, rd_req, in_ready}, 32'd2);
        ack_read();
        chk("R7 released", {30'd0, rd_req, in_ready}, 32'd1);
        chk("R7 rip clear", {31'd0, status[6]}, 32'd0);

        // R4, R3: random short write packets with random pads
        for (int p = 0; p < 40; p++) begin
            logic [3:0] a;
            int n;
            a = 4'($urandom % 16);
            if (a == 4'd4) a = 4'd5;
            n = 1 + int'($urandom % 4);
            send(hdr_short(2'd2, a, 11'(n)));
            for (int k = 0; k < n; k++) begin
                if ($urandom % 3 == 0) begin
                    send(PAD);
                    expect_none("R3 random pad");
                end
                d = $urandom;
                if (d == PAD) d = 32'd0;
                send(d);
                expect_wr("R4 random", a, d);
            end
        end

        // R8, R9: command write then desync mid-packet
        send(hdr_short(2'd2, 4'd4, 11'd3));
        send(32'd7);
        chk("R8 cmd strobe", {31'd0, cmd_wr}, 32'd1);
        chk("R8 cmd value", cmd_data, 32'd7);
        expect_wr("R8 write too", 4'd4, 32'd7);
        chk("R8 still aligned", {31'd0, status[7]}, 32'd1);
        send(32'd13);
        chk("R9 cmd strobe", {31'd0, cmd_wr}, 32'd1);
        chk("R9 unaligned", {31'd0, status[7]}, 32'd0);
        send(32'h5555_0000);
        expect_none("R9 rest dropped");
        send(hdr_short(2'd2, 4'd2, 11'd1));
        send(32'h6666_0000);
        expect_none("R9 searching");

        // R10: orphan long header after resync
        send(SYNC);
        chk("R10 err clear before", {31'd0, status[8]}, 32'd1);
        send(hdr_long(2'd2, 27'd1));
        chk("R10 orphan", {31'd0, status[8]}, 32'd0);
        send(hdr_short(2'd2, 4'd2, 11'd1));
        send(32'h7777_0000);
        expect_wr("R10 orphan dropped", 4'd2, 32'h7777_0000);
        chk("R10 sticky", {31'd0, status[8]}, 32'd0);

        // R10: bad packet type after a fresh reset
        do_reset();
        send(SYNC);
        send({3'd3, 29'd1});
        chk("R10 bad type", {31'd0, status[8]}, 32'd0);
        send(hdr_short(2'd3, 4'd1, 11'd1));
        chk("R10 bad op", {31'd0, status[0]}, 32'd1);
        send(hdr_short(2'd2, 4'd5, 11'd1));
        send(32'h8888_0000);
        expect_wr("R10 recovers", 4'd5, 32'h8888_0000);
        chk("R11 fixed ones", {27'd0, status[5:1]}, 32'h1F);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule